// File: doc/BRIEF.md
# Operand Data Break Comparator

This block is the data-value half of one hardware break channel in an on-chip debug unit. Software programs a 32-bit compare value, a 32-bit mask and a small control word through a register port. The block then watches every operand-bus access. It reports a combinational data-match result for the access presented in the current cycle. One clock later it raises a single-cycle break pulse when the access also meets the direction and size conditions.

Only the byte lanes that belong to the access size take part in the comparison. Byte and word operands sit right-aligned on the low lanes of the 64-bit bus. A longword uses the low 32 bits. A quadword is checked as two 32-bit halves, and both halves are compared against the same value and mask. Accesses flagged as carrying no data, such as cache invalidate, prefetch, write-back and purge operations, can never satisfy an enabled data condition.

Register map (`reg_addr`): 0 = compare value, 1 = compare mask, 2 = control, 3 = reads zero and ignores writes. Control bits: bit 0 is the data-condition enable. Bits 2:1 select the direction: 01 = reads only, 10 = writes only, 00 or 11 = either. Bits 4:3 hold the selected size code. Bit 5 turns the size selection on. Size codes are 00 byte, 01 word, 10 longword and 11 quadword.

Top module: `odb_data_break`

## Requirements
- R1: After reset the control register reads 0 and `brk_pulse` is 0. The compare value and mask have no defined reset value.
- R2: Writes to address 0 and address 1 read back all 32 bits. A write to address 2 keeps bits 5:0, and bits 31:6 read as 0.
- R3: For a byte access (size 00), only bus bits 7:0 are compared with compare bits 7:0. Compare bits 31:8 and bus bits 63:8 have no effect.
- R4: For a word access (size 01), bus bits 15:0 are compared with compare bits 15:0, and all higher bits have no effect.
- R5: For a longword access (size 10), bus bits 31:0 are compared with all 32 compare bits, and bus bits 63:32 have no effect.
- R6: A bus bit whose mask bit is 1 is left out of the comparison.
- R7: For a quadword access (size 11), bus bits 63:32 and bus bits 31:0 are each compared against the same compare value and mask. The data match holds only when both halves match.
- R8: With the data condition enabled, an access whose `acc_nodata` is 1 never gives a data match, whatever the bus carries.
- R9: With the data condition enabled and size selection off (control bit 5 = 0), `data_match` is 0 for every access.
- R10: With the data condition disabled (control bit 0 = 0), `data_match` is 1.
- R11: With size selection on, a break needs the access size to equal the selected size code.
- R12: Direction selection 01 breaks only on reads (`acc_write` = 0), 10 only on writes, and 00 or 11 on either.
- R13: `brk_pulse` is 1 for exactly the cycle after a clock edge at which `acc_valid` is 1 and the data, size and direction conditions all hold. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| acc_valid | input | 1 | Operand access present this cycle |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| acc_size | input | 2 | Access size code |
| acc_nodata | input | 1 | Access carries no data value |
| acc_data | input | 64 | Operand data bus |
| data_match | output | 1 | Data condition result for the current access |
| brk_pulse | output | 1 | Registered break pulse |

## Verification
The comparator is tried with three kinds of bus pattern. The first is an exact copy of the compare value, with garbage placed above the active lanes. This shows whether lanes outside the access size are really ignored. The second flips a single bit, either inside or outside the active lanes, sometimes under a set mask bit. This separates lane selection from masking. The third is a quadword in which only one half carries a mismatch, which shows that both halves are required. Random control words mix in nodata accesses, a disabled data condition, size selection turned off, and mismatched sizes and directions. These runs show that each gating condition can veto the break on its own.

// File: rtl/odb_pkg.sv
package odb_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10,
        SZ_QUAD = 2'b11
    } acc_size_e;

    typedef enum logic [1:0] {
        DIR_EITHER = 2'b00,
        DIR_READ   = 2'b01,
        DIR_WRITE  = 2'b10,
        DIR_BOTH   = 2'b11
    } dir_sel_e;

    typedef enum logic [1:0] {
        RA_VALUE = 2'b00,
        RA_MASK  = 2'b01,
        RA_CTRL  = 2'b10,
        RA_NONE  = 2'b11
    } reg_sel_e;

    // control word, packed MSB first: bit5 size_on, 4:3 size, 2:1 dir, 0 den
    typedef struct packed {
        logic      size_on;
        acc_size_e size;
        dir_sel_e  dir;
        logic      den;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        logic      valid;
        logic      write;
        acc_size_e size;
        logic      nodata;
    } acc_t;

    // number of low byte lanes that take part in one half compare
    function automatic int lane_bytes(acc_size_e sz, int half_bytes);
        case (sz)
            SZ_BYTE: return 1;
            SZ_WORD: return 2;
            default: return half_bytes;
        endcase
    endfunction

    function automatic logic dir_pass(dir_sel_e sel, logic is_write);
        case (sel)
            DIR_READ:  return !is_write;
            DIR_WRITE: return is_write;
            default:   return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/odb_cfg_regs.sv
module odb_cfg_regs
    import odb_pkg::*;
#(
    parameter int CMP_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  logic [1:0]       reg_addr,
    input  logic [CMP_W-1:0] reg_wdata,
    output logic [CMP_W-1:0] reg_rdata,
    output logic [CMP_W-1:0] cmp_value,
    output logic [CMP_W-1:0] cmp_mask,
    output ctrl_t            ctrl
);
    localparam int PAD_W = CMP_W - CTRL_W;

    reg_sel_e sel;
    assign sel = reg_sel_e'(reg_addr);

    // value and mask: reset state undefined, software loads them first
    always_ff @(posedge clk) begin
        if (reg_we && sel == RA_VALUE) cmp_value <= reg_wdata;
        if (reg_we && sel == RA_MASK)  cmp_mask  <= reg_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (reg_we && sel == RA_CTRL) begin
            ctrl <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
        end
    end

    always_comb begin
        case (sel)
            RA_VALUE: reg_rdata = cmp_value;
            RA_MASK:  reg_rdata = cmp_mask;
            RA_CTRL:  reg_rdata = {{PAD_W{1'b0}}, ctrl};
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/odb_half_cmp.sv
module odb_half_cmp
    import odb_pkg::*;
#(
    parameter int CMP_W = 32
) (
    input  logic [CMP_W-1:0] half_data,
    input  logic [CMP_W-1:0] cmp_value,
    input  logic [CMP_W-1:0] cmp_mask,
    input  acc_size_e        size,
    output logic             hit
);
    localparam int HALF_BYTES = CMP_W / 8;

    int               nbytes;
    logic [CMP_W-1:0] care;
    logic [CMP_W-1:0] diff;

    assign nbytes = lane_bytes(size, HALF_BYTES);

    always_comb begin
        for (int b = 0; b < CMP_W; b++) begin
            care[b] = (b / 8) < nbytes;
        end
    end

    assign diff = (half_data ^ cmp_value) & ~cmp_mask & care;
    assign hit  = (diff == '0);

endmodule

// File: rtl/odb_cond_eval.sv
module odb_cond_eval
    import odb_pkg::*;
#(
    parameter int CMP_W = 32,
    parameter int BUS_W = 64
) (
    input  ctrl_t            ctrl,
    input  acc_t             acc,
    input  logic [BUS_W-1:0] bus,
    input  logic [CMP_W-1:0] cmp_value,
    input  logic [CMP_W-1:0] cmp_mask,
    output logic             data_ok,
    output logic             access_hit
);
    localparam int NHALF = BUS_W / CMP_W;

    logic [NHALF-1:0] half_hit;
    logic [NHALF-1:0] half_need;
    logic             lanes_ok;
    logic             size_ok;
    logic             dir_ok;

    for (genvar h = 0; h < NHALF; h++) begin : g_half
        odb_half_cmp #(.CMP_W(CMP_W)) u_cmp (
            .half_data (bus[h*CMP_W +: CMP_W]),
            .cmp_value (cmp_value),
            .cmp_mask  (cmp_mask),
            .size      (acc.size),
            .hit       (half_hit[h])
        );
        // the low half always counts; upper halves only for a quadword
        if (h == 0) begin : g_low
            assign half_need[h] = 1'b1;
        end else begin : g_up
            assign half_need[h] = (acc.size == SZ_QUAD);
        end
    end

    assign lanes_ok = &(half_hit | ~half_need);

    always_comb begin
        if (!ctrl.den)             data_ok = 1'b1;
        else if (!ctrl.size_on)    data_ok = 1'b0;
        else if (acc.nodata)       data_ok = 1'b0;
        else                       data_ok = lanes_ok;
    end

    assign size_ok    = !ctrl.size_on || (acc.size == ctrl.size);
    assign dir_ok     = dir_pass(ctrl.dir, acc.write);
    assign access_hit = acc.valid && data_ok && size_ok && dir_ok;

endmodule

// File: rtl/odb_data_break.sv
module odb_data_break
    import odb_pkg::*;
#(
    parameter int CMP_W = 32,
    parameter int BUS_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  logic [1:0]       reg_addr,
    input  logic [CMP_W-1:0] reg_wdata,
    output logic [CMP_W-1:0] reg_rdata,
    input  logic             acc_valid,
    input  logic             acc_write,
    input  logic [1:0]       acc_size,
    input  logic             acc_nodata,
    input  logic [BUS_W-1:0] acc_data,
    output logic             data_match,
    output logic             brk_pulse
);
    logic [CMP_W-1:0] cmp_value;
    logic [CMP_W-1:0] cmp_mask;
    ctrl_t            ctrl_q;
    acc_t             acc;
    logic             access_hit;
    logic             cfg_den;
    logic             cfg_size_on;

    assign acc = '{valid:  acc_valid,
                   write:  acc_write,
                   size:   acc_size_e'(acc_size),
                   nodata: acc_nodata};

    assign cfg_den     = ctrl_q.den;
    assign cfg_size_on = ctrl_q.size_on;

    odb_cfg_regs #(.CMP_W(CMP_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cmp_value (cmp_value),
        .cmp_mask  (cmp_mask),
        .ctrl      (ctrl_q)
    );

    odb_cond_eval #(.CMP_W(CMP_W), .BUS_W(BUS_W)) u_eval (
        .ctrl       (ctrl_q),
        .acc        (acc),
        .bus        (acc_data),
        .cmp_value  (cmp_value),
        .cmp_mask   (cmp_mask),
        .data_ok    (data_match),
        .access_hit (access_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) brk_pulse <= 1'b0;
        else     brk_pulse <= access_hit;
    end

endmodule

// File: rtl/odb_data_break_chk.sv
module odb_data_break_chk (
    input logic clk,
    input logic rst,
    input logic acc_valid,
    input logic acc_nodata,
    input logic data_match,
    input logic brk_pulse,
    input logic cfg_den,
    input logic cfg_size_on
);
    assert_nodata_R8: assert property (@(posedge clk) disable iff (rst)
        (cfg_den && acc_nodata) |-> !data_match);

    assert_nosize_R9: assert property (@(posedge clk) disable iff (rst)
        (cfg_den && !cfg_size_on) |-> !data_match);

    assert_den_off_R10: assert property (@(posedge clk) disable iff (rst)
        !cfg_den |-> data_match);

    assert_idle_quiet_R13: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> !brk_pulse);

    assert_pulse_cause_R13: assert property (@(posedge clk) disable iff (rst)
        !data_match |=> !brk_pulse);

endmodule

bind odb_data_break odb_data_break_chk chk_i (.*);

// File: tb/odb_data_break_tb_top.sv
module odb_data_break_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_we;
    logic [1:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        acc_valid;
    logic        acc_write;
    logic [1:0]  acc_size;
    logic        acc_nodata;
    logic [63:0] acc_data;
    logic        data_match;
    logic        brk_pulse;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // shadow configuration held by the bench
    logic [31:0] m_val;
    logic [31:0] m_msk;
    logic [5:0]  m_ctl;

    always #10 clk = ~clk; // 50 MHz

    odb_data_break dut_i (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_valid(acc_valid),
        .acc_write(acc_write), .acc_size(acc_size), .acc_nodata(acc_nodata),
        .acc_data(acc_data), .data_match(data_match), .brk_pulse(brk_pulse)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic exp_dm(logic [1:0] sz, logic nd, logic [63:0] bus);
        logic [31:0] care;
        logic lo, hi;
        if (!m_ctl[0]) return 1'b1;
        if (!m_ctl[5]) return 1'b0;
        if (nd)        return 1'b0;
        care = (sz == 2'b00) ? 32'h0000_00FF :
               (sz == 2'b01) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
        lo = (((bus[31:0]  ^ m_val) & ~m_msk & care) == 32'h0);
        hi = (((bus[63:32] ^ m_val) & ~m_msk) == 32'h0);
        return (sz == 2'b11) ? (lo && hi) : lo;
    endfunction

    function automatic logic exp_bk(logic v, logic w, logic [1:0] sz, logic nd,
                                    logic [63:0] bus);
        logic dir_ok;
        dir_ok = (m_ctl[2:1] == 2'b01) ? !w : (m_ctl[2:1] == 2'b10) ? w : 1'b1;
        return v && exp_dm(sz, nd, bus) && dir_ok && (!m_ctl[5] || sz == m_ctl[4:3]);
    endfunction

    task automatic wr(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        case (a)
            2'd0: m_val = d;
            2'd1: m_msk = d;
            2'd2: m_ctl = d[5:0];
            default: ;
        endcase
    endtask

    task automatic cfg(logic [31:0] v, logic [31:0] m, logic [5:0] c);
        wr(2'd0, v); wr(2'd1, m); wr(2'd2, {26'h0, c});
    endtask

    // present one access; check match in-cycle and pulse after the edge
    task automatic acc(string req, logic v, logic w, logic [1:0] sz, logic nd,
                       logic [63:0] bus);
        @(negedge clk);
        acc_valid = v; acc_write = w; acc_size = sz; acc_nodata = nd; acc_data = bus;
        #2 chk({req, " data_match"}, data_match, exp_dm(sz, nd, bus));
        @(posedge clk);
        #2 chk({req, " brk_pulse"}, brk_pulse, exp_bk(v, w, sz, nd, bus));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0D0B));
        rst = 1'b1; reg_we = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
        acc_valid = 1'b0; acc_write = 1'b0; acc_size = 2'b00;
        acc_nodata = 1'b0; acc_data = '0;
        m_val = '0; m_msk = '0; m_ctl = '0;
        repeat (3) @(posedge clk);
        #2 chk("R1 brk after reset", brk_pulse, 0);
        reg_addr = 2'd2;
        #1 chk("R1 ctrl after reset", reg_rdata, 0);
        @(negedge clk); rst = 1'b0;

        // R2 register readback
        cfg(32'hA5C3_0F71, 32'h0000_0000, 6'h3F);
        @(negedge clk); reg_addr = 2'd0; #1 chk("R2 value", reg_rdata, 32'hA5C3_0F71);
        reg_addr = 2'd1; #1 chk("R2 mask", reg_rdata, 0);
        wr(2'd2, 32'hFFFF_FFC5);
        reg_addr = 2'd2; #1 chk("R2 ctrl upper bits zero", reg_rdata, 32'h0000_0005);
        wr(2'd3, 32'h1234_5678);
        reg_addr = 2'd3; #1 chk("R2 unused address", reg_rdata, 0);

        // R3 byte: high bits ignored
        cfg(32'h1234_56AB, 32'h0, 6'b1_00_00_1);
        acc("R3 byte junk above", 1, 0, 2'b00, 0, 64'hFFFF_FFFF_FFFF_FFAB);
        acc("R3 byte low mismatch", 1, 0, 2'b00, 0, 64'h0000_0000_1234_56AA);
        // R4 word
        cfg(32'h1234_BEEF, 32'h0, 6'b1_01_00_1);
        acc("R4 word junk above", 1, 1, 2'b01, 0, 64'h9999_9999_0000_BEEF);
        acc("R4 word bit15 differs", 1, 1, 2'b01, 0, 64'h0000_0000_1234_3EEF);
        // R5 longword, upper half ignored
        cfg(32'hCAFE_F00D, 32'h0, 6'b1_10_00_1);
        acc("R5 long upper junk", 1, 0, 2'b10, 0, 64'h0123_4567_CAFE_F00D);
        acc("R5 long bit31 differs", 1, 0, 2'b10, 0, 64'h0000_0000_4AFE_F00D);
        // R6 mask
        cfg(32'hCAFE_F00D, 32'h8000_0001, 6'b1_10_00_1);
        acc("R6 masked bits differ", 1, 0, 2'b10, 0, 64'h0000_0000_4AFE_F00C);
        acc("R6 unmasked bit differs", 1, 0, 2'b10, 0, 64'h0000_0000_CAFE_F00F);
        // R7 quadword
        cfg(32'h0BAD_CAFE, 32'h0, 6'b1_11_00_1);
        acc("R7 quad both halves", 1, 1, 2'b11, 0, 64'h0BAD_CAFE_0BAD_CAFE);
        acc("R7 quad upper differs", 1, 1, 2'b11, 0, 64'h0BAD_CAFF_0BAD_CAFE);
        acc("R7 quad lower differs", 1, 1, 2'b11, 0, 64'h0BAD_CAFE_1BAD_CAFE);
        // R8 nodata
        cfg(32'h0BAD_CAFE, 32'h0, 6'b1_10_00_1);
        acc("R8 nodata equal bus", 1, 1, 2'b10, 1, 64'h0000_0000_0BAD_CAFE);
        // R9 data on, size off
        cfg(32'h0BAD_CAFE, 32'h0, 6'b0_10_00_1);
        acc("R9 no size selected", 1, 0, 2'b10, 0, 64'h0000_0000_0BAD_CAFE);
        // R10 data condition off
        cfg(32'h0BAD_CAFE, 32'h0, 6'b0_00_00_0);
        acc("R10 den off mismatching bus", 1, 0, 2'b10, 1, 64'h0);
        // R11 size mismatch
        cfg(32'h0000_00AB, 32'h0, 6'b1_00_00_1);
        acc("R11 size differs", 1, 0, 2'b10, 0, 64'h0000_0000_0000_00AB);
        acc("R11 size equal", 1, 0, 2'b00, 0, 64'h0000_0000_0000_00AB);
        // R12 direction
        cfg(32'h0000_00AB, 32'h0, 6'b1_00_01_1);
        acc("R12 read-only sees write", 1, 1, 2'b00, 0, 64'hAB);
        acc("R12 read-only sees read", 1, 0, 2'b00, 0, 64'hAB);
        cfg(32'h0000_00AB, 32'h0, 6'b1_00_10_1);
        acc("R12 write-only sees read", 1, 0, 2'b00, 0, 64'hAB);
        acc("R12 write-only sees write", 1, 1, 2'b00, 0, 64'hAB);
        // R13 pulse lasts one cycle, invalid access never breaks
        acc("R13 hit", 1, 1, 2'b00, 0, 64'hAB);
        acc("R13 next cycle idle", 0, 1, 2'b00, 0, 64'hAB);

        // constrained random
        for (int i = 0; i < 600; i++) begin
            logic [1:0]  sz;
            logic [63:0] bus;
            logic [31:0] lo, hi;
            if (i % 40 == 0) begin
                logic [5:0] c;
                c = 6'($urandom);
                if ($urandom % 4 != 0) c[5] = 1'b1;
                if ($urandom % 4 != 0) c[0] = 1'b1;
                cfg($urandom, $urandom & $urandom & $urandom, c);
            end
            sz = (m_ctl[5] && $urandom % 3 != 0) ? m_ctl[4:3] : 2'($urandom);
            lo = m_val; hi = ($urandom % 2 == 0) ? m_val : $urandom;
            if ($urandom % 2 == 0) lo[$urandom % 32] ^= 1'b1;
            if ($urandom % 4 == 0) hi[$urandom % 32] ^= 1'b1;
            bus = {hi, lo};
            acc("R13 random", ($urandom % 6 != 0), 1'($urandom), sz,
                ($urandom % 8 == 0), bus);
        end

        @(negedge clk); acc_valid = 1'b0;
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule